// File: doc/BRIEF.md
# Parallel LFSR Noise Mixer

This block is a pseudo-random noise source for building test signals. A 23-bit Fibonacci shift register with the primitive feedback polynomial x^23 + x^18 + 1 is advanced sixteen positions on every enabled clock. A closed-form XOR of two bit ranges computes the step in one cycle, so it needs no sixteen-stage serial chain. The sixteen bits shifted in during a step are split into four 4-bit noise lanes. Every lane therefore carries different noise in the same cycle.

Each lane adds its noise value to one of four externally supplied 8-bit waveform samples, for example phase-shifted sine channels. The result is a registered noisy output. By default the sum is 9 bits wide, so no carry is lost. A saturate mode clamps it to 255 instead. A seed can be loaded at run time. The block guards against the all-zero lock-up state by substituting a fixed default seed.

Top module: `lfsr_noise_mixer`

## Requirements
- R1: While `rst` is high at a clock edge, the register is loaded with the default seed 23'h1B2C3D, and all noise and sum outputs become zero.
- R2: On each edge with `en` high, `seed_ld` low and `rst` low, the register advances exactly sixteen single steps of the Fibonacci register. One single step shifts the state left by one bit and puts state[22] XOR state[17] into bit 0.
- R3: The sixteen bits shifted in during one advance form a field. Its bit 15 is the first bit shifted in and its bit 0 is the last. Lane k (k = 0..3) outputs field bits [4k+3:4k] on `noiseK`.
- R4: With `sat_mode` low, each sum output is the 9-bit unsigned sum of that lane's sample and the lane's new noise value.
- R5: With `sat_mode` high, a sum above 255 is output as 9'h0FF. Other sums are output unchanged, and bit 8 is then always 0.
- R6: When `en`, `seed_ld` and `rst` are all low, the register and all outputs hold their values. The next advance continues the sequence from where it stopped.
- R7: When `seed_ld` is high (and `rst` low), the register takes the value of `seed` whatever the level of `en`. The outputs hold during that cycle.
- R8: A seed load with `seed` equal to zero loads the default seed 23'h1B2C3D instead.
- R9: Once out of reset, the register state is never zero.
- R10: A sample is reflected on its sum output after exactly one enabled clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the register and update the outputs |
| seed_ld | input | 1 | Load `seed` into the register; takes priority over `en` |
| seed | input | 23 | Seed value; zero is replaced by the default seed |
| sat_mode | input | 1 | 1 = clamp sums to 255, 0 = full 9-bit sum |
| samp0 | input | 8 | Waveform sample, lane 0 |
| samp1 | input | 8 | Waveform sample, lane 1 |
| samp2 | input | 8 | Waveform sample, lane 2 |
| samp3 | input | 8 | Waveform sample, lane 3 |
| noise0 | output | 4 | Registered noise, lane 0 |
| noise1 | output | 4 | Registered noise, lane 1 |
| noise2 | output | 4 | Registered noise, lane 2 |
| noise3 | output | 4 | Registered noise, lane 3 |
| sum0 | output | 9 | Registered noisy sample, lane 0 |
| sum1 | output | 9 | Registered noisy sample, lane 1 |
| sum2 | output | 9 | Registered noisy sample, lane 2 |
| sum3 | output | 9 | Registered noisy sample, lane 3 |

## Verification
The noise lanes are compared against a bit-serial model that runs sixteen single steps per cycle. This separates a wrong tap, a wrong shift direction and a swapped lane order from a correct closed-form step. The samples include all-zero, all-ones and values near 255. With these, carry into bit 8 and clamping are tested in both modes. Distinct per-lane samples expose crossed lane wiring. Hold cycles, loads with `en` high, a zero seed and a 5000-cycle run tell apart the control priorities and the lock-up guard.

// File: rtl/nm_pkg.sv
package nm_pkg;

    localparam int LFSR_W    = 23;
    localparam int TAP_LO    = 17;
    localparam int LANES     = 4;
    localparam int NOISE_W   = 4;
    localparam int SAMP_W    = 8;
    localparam int STEP_N    = LANES * NOISE_W;
    localparam int SUM_W     = SAMP_W + 1;
    localparam int KEEP_W    = LFSR_W - STEP_N;
    localparam int HI_OFS    = LFSR_W - STEP_N;
    localparam int LO_OFS    = TAP_LO + 1 - STEP_N;
    localparam logic [LFSR_W-1:0] DEFAULT_SEED = 23'h1B2C3D;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_RESET = 2'd3
    } act_e;

    // Bits shifted in during STEP_N single steps; bit STEP_N-1 enters first.
    function automatic logic [STEP_N-1:0] leap_bits(input logic [LFSR_W-1:0] s);
        logic [STEP_N-1:0] f;
        for (int i = 0; i < STEP_N; i++) begin
            f[i] = s[i + HI_OFS] ^ s[i + LO_OFS];
        end
        return f;
    endfunction

endpackage

// File: rtl/nm_ctrl.sv
module nm_ctrl
    import nm_pkg::*;
(
    input  logic rst,
    input  logic seed_ld,
    input  logic en,
    output act_e act
);
    // Priority: reset, then seed load, then advance, else hold.
    always_comb begin
        unique case (1'b1)
            rst:     act = ACT_RESET;
            seed_ld: act = ACT_LOAD;
            en:      act = ACT_STEP;
            default: act = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/nm_lfsr.sv
module nm_lfsr
    import nm_pkg::*;
(
    input  logic              clk,
    input  act_e              act,
    input  logic [LFSR_W-1:0] seed,
    output logic [LFSR_W-1:0] state,
    output logic [STEP_N-1:0] fresh
);
    logic [LFSR_W-1:0] st_q;
    logic [LFSR_W-1:0] seed_safe;

    always_comb begin
        fresh     = leap_bits(st_q);
        seed_safe = (seed == '0) ? DEFAULT_SEED : seed;
    end

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_RESET: st_q <= DEFAULT_SEED;
            ACT_LOAD:  st_q <= seed_safe;
            ACT_STEP:  st_q <= {st_q[KEEP_W-1:0], fresh};
            default:   st_q <= st_q;
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/nm_lane.sv
module nm_lane
    import nm_pkg::*;
(
    input  logic               clk,
    input  act_e               act,
    input  logic               sat_mode,
    input  logic [SAMP_W-1:0]  samp,
    input  logic [NOISE_W-1:0] nz,
    output logic [NOISE_W-1:0] noise_q,
    output logic [SUM_W-1:0]   sum_q
);
    logic [SUM_W-1:0] raw;
    logic [SUM_W-1:0] shaped;

    always_comb begin
        raw    = {1'b0, samp} + {{(SUM_W-NOISE_W){1'b0}}, nz};
        shaped = (sat_mode && raw[SUM_W-1]) ? {1'b0, {SAMP_W{1'b1}}} : raw;
    end

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_RESET: begin
                noise_q <= '0;
                sum_q   <= '0;
            end
            ACT_STEP: begin
                noise_q <= nz;
                sum_q   <= shaped;
            end
            default: begin
                noise_q <= noise_q;
                sum_q   <= sum_q;
            end
        endcase
    end

endmodule

// File: rtl/lfsr_noise_mixer.sv
module lfsr_noise_mixer
    import nm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              seed_ld,
    input  logic [LFSR_W-1:0] seed,
    input  logic              sat_mode,
    input  logic [SAMP_W-1:0] samp0,
    input  logic [SAMP_W-1:0] samp1,
    input  logic [SAMP_W-1:0] samp2,
    input  logic [SAMP_W-1:0] samp3,
    output logic [NOISE_W-1:0] noise0,
    output logic [NOISE_W-1:0] noise1,
    output logic [NOISE_W-1:0] noise2,
    output logic [NOISE_W-1:0] noise3,
    output logic [SUM_W-1:0]  sum0,
    output logic [SUM_W-1:0]  sum1,
    output logic [SUM_W-1:0]  sum2,
    output logic [SUM_W-1:0]  sum3
);
    act_e              act;
    logic [LFSR_W-1:0] lfsr_state;
    logic [STEP_N-1:0] fresh;
    logic [SAMP_W-1:0]  samp_a  [LANES];
    logic [NOISE_W-1:0] noise_a [LANES];
    logic [SUM_W-1:0]   sum_a   [LANES];

    assign samp_a[0] = samp0;
    assign samp_a[1] = samp1;
    assign samp_a[2] = samp2;
    assign samp_a[3] = samp3;

    nm_ctrl u_ctrl (
        .rst     (rst),
        .seed_ld (seed_ld),
        .en      (en),
        .act     (act)
    );

    nm_lfsr u_lfsr (
        .clk   (clk),
        .act   (act),
        .seed  (seed),
        .state (lfsr_state),
        .fresh (fresh)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        nm_lane u_lane (
            .clk      (clk),
            .act      (act),
            .sat_mode (sat_mode),
            .samp     (samp_a[k]),
            .nz       (fresh[k*NOISE_W +: NOISE_W]),
            .noise_q  (noise_a[k]),
            .sum_q    (sum_a[k])
        );
    end

    assign noise0 = noise_a[0];
    assign noise1 = noise_a[1];
    assign noise2 = noise_a[2];
    assign noise3 = noise_a[3];
    assign sum0   = sum_a[0];
    assign sum1   = sum_a[1];
    assign sum2   = sum_a[2];
    assign sum3   = sum_a[3];

endmodule

module nm_checks
    import nm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              seed_ld,
    input logic [LFSR_W-1:0] seed,
    input logic              sat_mode,
    input logic [SAMP_W-1:0] samp0,
    input logic [NOISE_W-1:0] noise0,
    input logic [SUM_W-1:0]  sum0,
    input logic [SUM_W-1:0]  sum3,
    input logic [LFSR_W-1:0] st
);
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (st == DEFAULT_SEED) && (sum0 == '0) && (noise0 == '0));

    p_shift_keep_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        (en && !seed_ld) |=> st[LFSR_W-1:STEP_N] == $past(st[KEEP_W-1:0]));

    p_sum_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        (en && !seed_ld && !sat_mode) |=>
            sum0 == ({1'b0, $past(samp0)} + {5'b0, noise0}));

    p_clamp_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        (en && !seed_ld && sat_mode) |=> !sum0[SUM_W-1] && !sum3[SUM_W-1]);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        (!en && !seed_ld) |=> $stable(st) && $stable(sum0) && $stable(noise0));

    p_load_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        (seed_ld && seed != '0) |=> (st == $past(seed)) && $stable(sum0));

    p_zero_seed_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        (seed_ld && seed == '0) |=> st == DEFAULT_SEED);

    p_nonzero_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        st != '0);

endmodule

bind lfsr_noise_mixer nm_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .seed_ld  (seed_ld),
    .seed     (seed),
    .sat_mode (sat_mode),
    .samp0    (samp0),
    .noise0   (noise0),
    .sum0     (sum0),
    .sum3     (sum3),
    .st       (lfsr_state)
);

// File: tb/tb_lfsr_noise_mixer.sv
module tb_lfsr_noise_mixer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [22:0] DEF_SEED = 23'h1B2C3D;

    // Vector: {en, seed_ld, sat_mode, samp3, samp2, samp1, samp0, seed}
    localparam int NVEC = 16;
    localparam logic [57:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 32'h00000000, 23'h0},
        {1'b1, 1'b0, 1'b0, 32'hFFFFFFFF, 23'h0},
        {1'b1, 1'b0, 1'b1, 32'hFFFFFFFF, 23'h0},
        {1'b1, 1'b0, 1'b0, 32'h40302010, 23'h0},
        {1'b0, 1'b0, 1'b0, 32'hAAAAAAAA, 23'h0},
        {1'b1, 1'b0, 1'b1, 32'hFBFAF9F8, 23'h0},
        {1'b1, 1'b1, 1'b0, 32'h12345678, 23'h000001},
        {1'b1, 1'b0, 1'b0, 32'h04030201, 23'h0},
        {1'b1, 1'b0, 1'b0, 32'hFE817F80, 23'h0},
        {1'b0, 1'b1, 1'b0, 32'h00000000, 23'h0},
        {1'b1, 1'b0, 1'b0, 32'h00000000, 23'h0},
        {1'b0, 1'b0, 1'b1, 32'h99999999, 23'h0},
        {1'b1, 1'b0, 1'b0, 32'hF3F2F1F0, 23'h0},
        {1'b0, 1'b1, 1'b0, 32'h00000000, 23'h7FFFFF},
        {1'b1, 1'b0, 1'b0, 32'hA55AAA55, 23'h0},
        {1'b1, 1'b0, 1'b1, 32'h0180FF00, 23'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        seed_ld = 1'b0;
    logic [22:0] seed = '0;
    logic        sat_mode = 1'b0;
    logic [7:0]  samp [4];
    logic [3:0]  noise [4];
    logic [8:0]  sum [4];

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    logic [22:0] m_st;
    logic [3:0]  e_noise [4];
    logic [8:0]  e_sum [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    lfsr_noise_mixer dut (
        .clk(clk), .rst(rst), .en(en), .seed_ld(seed_ld), .seed(seed),
        .sat_mode(sat_mode),
        .samp0(samp[0]), .samp1(samp[1]), .samp2(samp[2]), .samp3(samp[3]),
        .noise0(noise[0]), .noise1(noise[1]), .noise2(noise[2]), .noise3(noise[3]),
        .sum0(sum[0]), .sum1(sum[1]), .sum2(sum[2]), .sum3(sum[3])
    );

    // Bit-serial reference: sixteen single steps of x^23 + x^18 + 1.
    function automatic logic [22:0] serial16(input logic [22:0] s);
        logic [22:0] t = s;
        for (int i = 0; i < 16; i++) begin
            t = {t[21:0], t[22] ^ t[17]};
        end
        return t;
    endfunction

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string ntag, input string stag);
        for (int k = 0; k < 4; k++) begin
            chk(ntag, {5'b0, noise[k]}, {5'b0, e_noise[k]});
            chk(stag, sum[k], e_sum[k]);
        end
    endtask

    // Drive at negedge, model at posedge, check at next negedge.
    task automatic apply(input logic v_en, input logic v_ld, input logic v_sat,
                         input logic [31:0] v_samp, input logic [22:0] v_seed);
        logic [22:0] nx;
        logic [8:0]  raw;
        en = v_en; seed_ld = v_ld; sat_mode = v_sat; seed = v_seed;
        for (int k = 0; k < 4; k++) samp[k] = v_samp[k*8 +: 8];
        @(posedge clk);
        if (v_ld) begin
            m_st = (v_seed == '0) ? DEF_SEED : v_seed;
        end else if (v_en) begin
            nx = serial16(m_st);
            for (int k = 0; k < 4; k++) begin
                e_noise[k] = nx[k*4 +: 4];
                raw = {1'b0, v_samp[k*8 +: 8]} + {5'b0, nx[k*4 +: 4]};
                e_sum[k] = (v_sat && raw[8]) ? 9'h0FF : raw;
            end
            m_st = nx;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0; seed_ld = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_st = DEF_SEED;
        for (int k = 0; k < 4; k++) begin
            e_noise[k] = '0;
            e_sum[k] = '0;
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        string ntag, stag;
        for (int k = 0; k < 4; k++) samp[k] = '0;
        @(negedge clk);
        do_reset();
        // R1: reset state at the ports
        check_outputs("R1 reset noise", "R1 reset sum");

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [57:0] e = VEC[v];
            apply(e[57], e[56], e[55], e[54:23], e[22:0]);
            if (e[56])       begin ntag = "R7 load hold noise"; stag = "R7 load hold sum"; end
            else if (!e[57]) begin ntag = "R6 hold noise";      stag = "R6 hold sum";      end
            else if (e[55])  begin ntag = "R2/R3 noise";        stag = "R5 clamp sum";     end
            else             begin ntag = "R2/R3 noise";        stag = "R4 sum";           end
            check_outputs(ntag, stag);
        end

        // R6: after hold, sequence continues
        apply(1'b0, 1'b0, 1'b0, 32'h11111111, 23'h0);
        apply(1'b1, 1'b0, 1'b0, 32'h00000000, 23'h0);
        check_outputs("R6 resume noise", "R6 resume sum");

        // R8: zero seed loads default; first step equals step from reset
        apply(1'b0, 1'b1, 1'b0, 32'h0, 23'h0);
        apply(1'b1, 1'b0, 1'b0, 32'h0, 23'h0);
        check_outputs("R8 zero seed noise", "R8 zero seed sum");

        // R10: sum unchanged before the edge, updated after exactly one edge
        apply(1'b1, 1'b0, 1'b0, 32'h0, 23'h0);
        en = 1'b1; seed_ld = 1'b0; sat_mode = 1'b0;
        for (int k = 0; k < 4; k++) samp[k] = 8'hC0 + 8'(k);
        #1;
        for (int k = 0; k < 4; k++) chk("R10 before edge", sum[k], e_sum[k]);
        apply(1'b1, 1'b0, 1'b0, 32'hC3C2C1C0, 23'h0);
        check_outputs("R10 noise", "R10 after edge");

        // R1: mid-run reset clears outputs, restarts from default seed
        do_reset();
        check_outputs("R1 rereset noise", "R1 rereset sum");
        apply(1'b1, 1'b0, 1'b0, 32'h0, 23'h0);
        check_outputs("R1 first step noise", "R1 first step sum");

        // R9: long run against the serial model; model state never zero
        for (int c = 0; c < 5000; c++) begin
            apply(1'b1, 1'b0, 1'b0, 32'h0, 23'h0);
            for (int k = 0; k < 4; k++) chk("R9/R2 long noise", {5'b0, noise[k]}, {5'b0, e_noise[k]});
            chk("R9 nonzero state", {8'b0, (m_st == '0)}, 9'd0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule